// File: doc/BRIEF.md
# Variable-Advance Deserializer with Frame Lock

This block sits behind a multi-sample phase follower that, every receive clock, hands over up to two recovered line bits and a code saying how many of them are new: none, one, or two. It packs those bits into a word-wide window that can advance by zero, one or two positions in one clock. Once the window holds a programmable frame pattern, the block counts incoming bits modulo the word width. Each time a full word has arrived, it presents that word with a one-cycle valid strobe.

The block makes no assumption about the line code. Start-up consists of a short idle run with 0-to-1 transitions, then the frame pattern, then data words sent most significant bit first. A mask selects which pattern bits take part in the comparison. The pattern is compared after every single bit, including the intermediate position inside a two-bit advance. When a two-bit advance straddles a word boundary, the word is cut at the exact bit and the leftover bit becomes the first bit of the next word. A loss-of-lock pulse drops the frame lock so that a fresh search starts.

Top module: `tsdes_top`

## Requirements
- R1: After a synchronous reset, `frame_found` and `word_valid` are 0 and `word_out` is all zeros.
- R2: Shift code 0 adds no bit: it produces no word and moves no word boundary.
- R3: Shift code 1 appends `bit_b0` as the newest bit.
- R4: Shift code 2 appends `bit_b1` as the older bit, then `bit_b0` as the newest bit.
- R5: Shift code 3 is invalid and is treated exactly like code 0; the bits driven with it are discarded.
- R6: While unlocked, the newest WORD_W bits are compared with `frame_pat` after every appended bit, including the point between the two bits of a code-2 advance. A match sets `frame_found` on the next clock.
- R7: Only the bit positions where `frame_mask` is 1 take part in the comparison; a 0 bit marks a don't-care.
- R8: After lock, every WORD_W received bits form one word (first received bit in the MSB). The word is shown on `word_out` with `word_valid` high for exactly one cycle, one clock after the bit that completes it. The first word starts with the bit right after the frame.
- R9: If a code-2 advance completes a word with `bit_b1`, the word ends at `bit_b1` and `bit_b0` becomes the first bit of the following word.
- R10: `lock_lost` clears `frame_found`, the bit count and `word_valid` on the next clock. No word is produced until a new frame has been found.
- R11: `word_valid` is never high unless the frame was found, and it pulses at most once per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_lost | input | 1 | Drops the frame lock and the bit count |
| shift_code | input | 2 | Number of new bits this cycle (0, 1, 2; 3 invalid) |
| bit_b0 | input | 1 | Newest recovered bit |
| bit_b1 | input | 1 | Older recovered bit, used only with code 2 |
| frame_pat | input | WORD_W | Frame pattern, oldest bit in the MSB |
| frame_mask | input | WORD_W | 1 = compare this pattern bit |
| word_out | output | WORD_W | Last completed word, first bit in the MSB |
| word_valid | output | 1 | One-cycle strobe for a new word |
| frame_found | output | 1 | Frame lock flag |

## Verification
A bit count that is off by one rotates every later word by one position, so the first word after the frame already comes out wrong. A frame match missed at the intermediate point of a two-bit advance produces one of two visible faults: the frame is never found, or every word after it is shifted by one bit, one clock after the completing bit. A window that moves on a hold or invalid code corrupts the word that is then being assembled. A lock flag that survives loss of lock yields extra words that no frame preceded, and these appear as surplus strobes within a few bits.

// File: rtl/tsdes_pkg.sv
package tsdes_pkg;

    localparam int MAXW = 32;

    typedef enum logic [1:0] {
        SH_HOLD = 2'd0,
        SH_ONE  = 2'd1,
        SH_TWO  = 2'd2,
        SH_BAD  = 2'd3
    } shift_e;

    typedef struct packed {
        logic at_mid;
        logic at_fin;
    } hit_t;

    function automatic logic masked_eq(input logic [MAXW-1:0] a,
                                       input logic [MAXW-1:0] b,
                                       input logic [MAXW-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction

endpackage

// File: rtl/tsdes_window.sv
module tsdes_window
    import tsdes_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_e            code,
    input  logic              b0,
    input  logic              b1,
    output logic [WORD_W-1:0] win_q,
    output logic [WORD_W-1:0] mid_w,
    output logic [WORD_W-1:0] fin_w,
    output logic [1:0]        nbits
);

    always_comb begin
        mid_w = {win_q[WORD_W-2:0], b1};
        unique case (code)
            SH_ONE: begin
                fin_w = {win_q[WORD_W-2:0], b0};
                nbits = 2'd1;
            end
            SH_TWO: begin
                fin_w = {mid_w[WORD_W-2:0], b0};
                nbits = 2'd2;
            end
            default: begin
                fin_w = win_q;
                nbits = 2'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= fin_w;
    end

    a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (code == SH_HOLD) |=> $stable(win_q));
    a_r5_bad_ignored: assert property (@(posedge clk) disable iff (rst)
        (code == SH_BAD) |=> $stable(win_q));
    a_r3_one_bit: assert property (@(posedge clk) disable iff (rst)
        (code == SH_ONE) |=> (win_q[0] == $past(b0)) && (win_q[1] == $past(win_q[0])));
    a_r4_two_bits: assert property (@(posedge clk) disable iff (rst)
        (code == SH_TWO) |=> (win_q[1:0] == {$past(b1), $past(b0)}));

endmodule

// File: rtl/tsdes_seek.sv
module tsdes_seek
    import tsdes_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] mid_w,
    input  logic [WORD_W-1:0] fin_w,
    input  logic [1:0]        nbits,
    input  logic [WORD_W-1:0] pat,
    input  logic [WORD_W-1:0] mask,
    output hit_t              hit
);

    always_comb begin
        hit.at_mid = (nbits == 2'd2) &&
                     masked_eq(MAXW'(mid_w), MAXW'(pat), MAXW'(mask));
        hit.at_fin = (nbits != 2'd0) &&
                     masked_eq(MAXW'(fin_w), MAXW'(pat), MAXW'(mask));
    end

endmodule

// File: rtl/tsdes_framer.sv
module tsdes_framer
    import tsdes_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  hit_t              hit,
    input  logic [1:0]        nbits,
    input  logic [WORD_W-1:0] mid_w,
    input  logic [WORD_W-1:0] fin_w,
    output logic [WORD_W-1:0] word_q,
    output logic              valid_q,
    output logic              found_q
);

    localparam int CW = $clog2(WORD_W + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] sum;

    assign sum = cnt_q + CW'(nbits);

    always_ff @(posedge clk) begin
        if (rst) begin
            found_q <= 1'b0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (clear) begin
            found_q <= 1'b0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!found_q) begin
                if (hit.at_mid) begin
                    found_q <= 1'b1;
                    cnt_q   <= CW'(1);
                end else if (hit.at_fin) begin
                    found_q <= 1'b1;
                    cnt_q   <= '0;
                end
            end else if (nbits == 2'd2 && cnt_q == CW'(WORD_W - 1)) begin
                word_q  <= mid_w;
                valid_q <= 1'b1;
                cnt_q   <= CW'(1);
            end else if (sum == CW'(WORD_W)) begin
                word_q  <= fin_w;
                valid_q <= 1'b1;
                cnt_q   <= '0;
            end else begin
                cnt_q <= sum;
            end
        end
    end

    a_r8_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(WORD_W));
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clear |=> !found_q && !valid_q);
    a_r11_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(found_q));
    a_r9_carry_bit: assert property (@(posedge clk) disable iff (rst)
        (found_q && !clear && nbits == 2'd2 && cnt_q == CW'(WORD_W - 1))
            |=> valid_q && cnt_q == CW'(1));

endmodule

// File: rtl/tsdes_top.sv
module tsdes_top
    import tsdes_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_lost,
    input  logic [1:0]        shift_code,
    input  logic              bit_b0,
    input  logic              bit_b1,
    input  logic [WORD_W-1:0] frame_pat,
    input  logic [WORD_W-1:0] frame_mask,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              frame_found
);

    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] mid_w;
    logic [WORD_W-1:0] fin_w;
    logic [1:0]        nbits;
    hit_t              hit;

    tsdes_window #(.WORD_W(WORD_W)) u_window (
        .clk   (clk),
        .rst   (rst),
        .code  (shift_e'(shift_code)),
        .b0    (bit_b0),
        .b1    (bit_b1),
        .win_q (win_q),
        .mid_w (mid_w),
        .fin_w (fin_w),
        .nbits (nbits)
    );

    tsdes_seek #(.WORD_W(WORD_W)) u_seek (
        .mid_w (mid_w),
        .fin_w (fin_w),
        .nbits (nbits),
        .pat   (frame_pat),
        .mask  (frame_mask),
        .hit   (hit)
    );

    tsdes_framer #(.WORD_W(WORD_W)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .clear   (lock_lost),
        .hit     (hit),
        .nbits   (nbits),
        .mid_w   (mid_w),
        .fin_w   (fin_w),
        .word_q  (word_out),
        .valid_q (word_valid),
        .found_q (frame_found)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !word_valid && !frame_found && word_out == '0);

endmodule

// File: tb/tsdes_top_bench.sv
module tsdes_top_bench;

    localparam int W    = 10;
    localparam int NW   = 8;
    localparam int MAXB = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic         lock_lost = 1'b0;
    logic [1:0]   shift_code = 2'd0;
    logic         bit_b0 = 1'b0;
    logic         bit_b1 = 1'b0;
    logic [W-1:0] frame_pat = 10'b1111100000;
    logic [W-1:0] frame_mask = '1;
    logic [W-1:0] word_out;
    logic         word_valid;
    logic         frame_found;

    int errors = 0;
    int checks = 0;
    int got = 0;
    int nexp = 0;
    logic         strm [0:MAXB-1];
    int           slen = 0;
    logic [W-1:0] exp_words [0:NW-1];
    logic [15:0]  lf = 16'hACE1;

    always #5 clk = ~clk;

    tsdes_top #(.WORD_W(W)) u_tsdes_top (
        .clk(clk), .rst(rst), .lock_lost(lock_lost), .shift_code(shift_code),
        .bit_b0(bit_b0), .bit_b1(bit_b1), .frame_pat(frame_pat),
        .frame_mask(frame_mask), .word_out(word_out),
        .word_valid(word_valid), .frame_found(frame_found)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R8 / R9 / R11: every strobe must carry the next expected word
    always @(negedge clk) begin
        if (word_valid) begin
            if (got < nexp)
                chk(word_out == exp_words[got], "R8 word value", int'(word_out), int'(exp_words[got]));
            else
                chk(1'b0, "R11 surplus word", got + 1, nexp);
            got++;
        end
    end

    task automatic build(input int idle_n, input logic [W-1:0] frame_bits,
                         input int nwords, input int seed);
        slen = 0;
        for (int i = 0; i < idle_n; i++) begin strm[slen] = logic'(i % 2); slen++; end
        for (int i = W - 1; i >= 0; i--) begin strm[slen] = frame_bits[i]; slen++; end
        for (int j = 0; j < nwords; j++) begin
            exp_words[j] = W'((j * 173 + seed * 31 + 5) % 1024);
            for (int i = W - 1; i >= 0; i--) begin strm[slen] = exp_words[j][i]; slen++; end
        end
        for (int i = 0; i < W - 1; i++) begin strm[slen] = logic'(i % 2); slen++; end
        nexp = nwords;
        got = 0;
    endtask

    task automatic clear_run(input bit use_rst);
        @(negedge clk);
        rst = use_rst;
        lock_lost = !use_rst;
        shift_code = 2'd0;
        @(negedge clk);
        rst = 1'b0;
        lock_lost = 1'b0;
        chk(frame_found == 1'b0, use_rst ? "R1 lock after reset" : "R10 lock after loss",
            int'(frame_found), 0);
        chk(word_valid == 1'b0, use_rst ? "R1 strobe after reset" : "R10 strobe after loss",
            int'(word_valid), 0);
    endtask

    // mode 0: all code 1 (R3); 1: all code 2 (R4); 2: mix with holds (R2); 3: any code incl. 3 (R5)
    task automatic send(input int mode);
        int pos = 0;
        int k = 0;
        logic [1:0] c;
        while (pos < slen) begin
            case (mode)
                0: c = 2'd1;
                1: c = 2'd2;
                2: begin
                    case (k % 6)
                        0: c = 2'd2;
                        1: c = 2'd0;
                        2: c = 2'd1;
                        3: c = 2'd2;
                        4: c = 2'd2;
                        default: c = 2'd1;
                    endcase
                end
                default: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    c = lf[1:0];
                end
            endcase
            if (c == 2'd2 && pos == slen - 1) c = 2'd1;
            @(negedge clk);
            shift_code = c;
            if (c == 2'd1) begin
                bit_b0 = strm[pos];
                bit_b1 = ~strm[pos];
                pos++;
            end else if (c == 2'd2) begin
                bit_b1 = strm[pos];
                bit_b0 = strm[pos + 1];
                pos += 2;
            end else begin
                bit_b0 = lf[3];
                bit_b1 = lf[4];
            end
            k++;
        end
        // R2: hold cycles must add no word
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            shift_code = 2'd0;
            bit_b0 = logic'(i % 2);
            bit_b1 = ~bit_b0;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(word_out == '0, "R1 word after reset", int'(word_out), 0);
        chk(frame_found == 1'b0, "R1 lock after reset", int'(frame_found), 0);
        chk(word_valid == 1'b0, "R1 strobe after reset", int'(word_valid), 0);

        // R6 (match at final and intermediate point), R8, R9, R10
        for (int idle_n = 10; idle_n <= 11; idle_n++) begin
            for (int mode = 0; mode < 4; mode++) begin
                frame_pat = 10'b1111100000;
                frame_mask = '1;
                clear_run(mode % 2 == 0);
                build(idle_n, 10'b1111100000, NW, idle_n * 4 + mode);
                send(mode);
                chk(frame_found == 1'b1, "R6 frame found", int'(frame_found), 1);
                chk(got == nexp, "R8 word count", got, nexp);
            end
        end

        // R7: masked-off bits differ, comparison still hits
        frame_pat = 10'b1111100000;
        frame_mask = 10'b0000011111;
        clear_run(1'b0);
        build(11, 10'b1010100000, NW, 77);
        send(1);
        chk(frame_found == 1'b1, "R7 masked match", int'(frame_found), 1);
        chk(got == nexp, "R7 masked word count", got, nexp);

        // R7: with full mask the same stream must not lock
        frame_mask = '1;
        clear_run(1'b1);
        build(11, 10'b1010100000, 0, 0);
        send(3);
        chk(frame_found == 1'b0, "R7 full mask no match", int'(frame_found), 0);
        chk(got == 0, "R11 no word without lock", got, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule